// File: doc/BRIEF.md
# Multi-core mailbox interrupt controller

This block gives every processor core in a small cluster a bank of 32-bit mailboxes. Any core can post bits into any mailbox. The core that owns a mailbox reads it and acknowledges it by clearing bits. Each core has one interrupt line. The line is high while at least one of that core's enabled mailboxes holds a non-zero value. A mailbox is therefore both a doorbell and a data word. One core can send an inter-processor interrupt by writing a non-zero token into the target's mailbox. A boot core can hand a jump address to a secondary core, which polls its mailbox 3 until the word becomes non-zero.

Every mailbox has two register views. The set view ORs the written data into the mailbox and reads as zero. The clear view returns the current contents when read and clears the bits written as one. A per-core enable register selects which mailboxes may drive that core's interrupt. Access goes through a single-cycle port with valid, write, word-aligned address and data. Read data is registered.

Top module: `mbox_ipi_ctrl`

## Requirements
- R1: After reset every mailbox and every enable register reads zero, every `irq` bit is low and `rsp_rdata` is zero.
- R2: The set view of mailbox b of core c is at byte offset 0x10*c + 4*b. Its clear view is at 0x40 + 0x10*c + 4*b. The enable register of core c is at 0x80 + 4*c. Address bits [1:0] must be zero.
- R3: A write to a set view ORs the write data into the mailbox, so bits already set are kept.
- R4: A write to a clear view clears exactly the bits written as one and leaves the other bits unchanged.
- R5: A read of a clear view returns the mailbox value on `rsp_rdata` in the cycle after the read. The read changes no state.
- R6: `irq[c]` is high exactly when some mailbox b of core c is non-zero and bit b of core c's enable register is set. The change is visible just after the clock edge that accepts the causing write.
- R7: `irq[c]` stays high after a clear that leaves any enabled mailbox non-zero. It drops only once every enabled mailbox of that core is zero.
- R8: A non-zero mailbox whose enable bit is zero does not raise `irq`. Setting the enable bit later raises `irq` while the mailbox is still non-zero.
- R9: Reads of unmapped or misaligned offsets return zero and writes to them change nothing. Reads of a set view return zero.
- R10: A read of an enable register returns its enable bits in bits [3:0]. All higher bits read zero, even after a write of all ones.
- R11: Writing zero to a set view leaves the mailbox unchanged.
- R12: A write to one mailbox changes no other mailbox, including the same mailbox number of another core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Access request valid this cycle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (8) | Byte offset, word aligned |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, one cycle after the read, zero otherwise |
| irq | output | NUM_CORES (4) | One interrupt line per core |

## Verification
A write takes effect at the clock edge that accepts it. The updated mailbox can be read by the next access, and its data returns on `rsp_rdata` one cycle after that read is accepted. With the default combinational interrupt merge, `irq` follows the new mailbox and enable state right after the accepting edge. Every bench task drives a request at a falling edge and samples results at the next falling edge. Read data and interrupt levels are therefore always observed half a period after the edge that produced them. No check is ever made in the cycle of the request itself.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   localparam int unsigned WORD_BYTES  = 4;
   localparam int unsigned BANK_STRIDE = 16;
   localparam int unsigned REGION_SPAN = 64;

   typedef enum logic [1:0] {
      RGN_SET  = 2'd0,
      RGN_CLR  = 2'd1,
      RGN_CTRL = 2'd2,
      RGN_NONE = 2'd3
   } mbox_rgn_e;

   typedef struct packed {
      mbox_rgn_e  rgn;
      logic [1:0] core;
      logic [1:0] box;
   } mbox_sel_t;

   function automatic int unsigned set_off(int unsigned core, int unsigned box);
      return core * BANK_STRIDE + box * WORD_BYTES;
   endfunction

   function automatic int unsigned clr_off(int unsigned core, int unsigned box);
      return REGION_SPAN + set_off(core, box);
   endfunction

   function automatic int unsigned ctrl_off(int unsigned core);
      return 2 * REGION_SPAN + core * WORD_BYTES;
   endfunction

endpackage

// File: rtl/mbox_addr_decode.sv
module mbox_addr_decode
   import mbox_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned NUM_BOXES = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output mbox_sel_t         sel
);

   logic hi_ok;
   logic aligned;

   generate
      if (ADDR_W > 8) begin : g_hi
         assign hi_ok = ~|addr[ADDR_W-1:8];
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      sel.rgn  = RGN_NONE;
      sel.core = addr[5:4];
      sel.box  = addr[3:2];
      if (hi_ok && aligned) begin
         unique case (addr[7:6])
            2'b00: if (32'(addr[5:4]) < NUM_CORES && 32'(addr[3:2]) < NUM_BOXES)
                      sel.rgn = RGN_SET;
            2'b01: if (32'(addr[5:4]) < NUM_CORES && 32'(addr[3:2]) < NUM_BOXES)
                      sel.rgn = RGN_CLR;
            2'b10: if (addr[5:4] == 2'b00 && 32'(addr[3:2]) < NUM_CORES) begin
                      sel.rgn  = RGN_CTRL;
                      sel.core = addr[3:2];
                      sel.box  = 2'b00;
                   end
            default: sel.rgn = RGN_NONE;
         endcase
      end
   end

endmodule

// File: rtl/mbox_slot.sv
module mbox_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_bits,
   input  logic [DATA_W-1:0] clr_bits,
   output logic [DATA_W-1:0] value
);

   // set wins over clear on overlapping bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else
         value <= (value & ~clr_bits) | set_bits;
   end

endmodule

// File: rtl/mbox_irq_merge.sv
module mbox_irq_merge #(
   parameter int unsigned NUM_BOXES = 4,
   parameter int unsigned DATA_W    = 32
) (
   input  logic [NUM_BOXES*DATA_W-1:0] boxes,
   input  logic [NUM_BOXES-1:0]        en,
   output logic                        pending
);

   logic [NUM_BOXES-1:0] live;

   generate
      for (genvar b = 0; b < NUM_BOXES; b++) begin : g_box
         assign live[b] = en[b] & (|boxes[b*DATA_W +: DATA_W]);
      end
   endgenerate

   assign pending = |live;

endmodule

// File: rtl/mbox_ipi_ctrl.sv
module mbox_ipi_ctrl
   import mbox_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned NUM_BOXES = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter bit          REG_IRQ   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_vld,
   input  logic                 req_wr,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic [NUM_CORES-1:0] irq
);

   localparam int unsigned NUM_SLOTS = NUM_CORES * NUM_BOXES;
   localparam int unsigned FLAT_W    = NUM_SLOTS * DATA_W;

   generate
      if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
         $error("mbox_ipi_ctrl: NUM_CORES must be 1..4");
      end
      if (NUM_BOXES < 1 || NUM_BOXES > 4) begin : g_bad_boxes
         $error("mbox_ipi_ctrl: NUM_BOXES must be 1..4");
      end
      if (DATA_W < NUM_BOXES) begin : g_bad_data
         $error("mbox_ipi_ctrl: DATA_W must hold the enable bits");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("mbox_ipi_ctrl: ADDR_W must be at least 8");
      end
   endgenerate

   mbox_sel_t                  sel;
   logic                       wr_hit;
   logic                       rd_hit;
   logic [FLAT_W-1:0]          box_flat;
   logic [NUM_SLOTS-1:0]       en_flat;
   logic [NUM_CORES-1:0]       pend;
   logic [DATA_W-1:0]          rd_word;
   logic [DATA_W-1:0]          rdata_q;

   assign wr_hit = req_vld &  req_wr;
   assign rd_hit = req_vld & ~req_wr;

   mbox_addr_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_CORES(NUM_CORES),
      .NUM_BOXES(NUM_BOXES)
   ) i_decode (
      .addr(req_addr),
      .sel (sel)
   );

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         localparam logic [1:0] CI = 2'(c);
         logic [NUM_BOXES-1:0] en_q;
         logic                 ctrl_we;

         assign ctrl_we = wr_hit && sel.rgn == RGN_CTRL && sel.core == CI;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en_q <= '0;
            else if (ctrl_we)
               en_q <= req_wdata[NUM_BOXES-1:0];
         end

         assign en_flat[c*NUM_BOXES +: NUM_BOXES] = en_q;

         for (genvar b = 0; b < NUM_BOXES; b++) begin : g_box
            localparam logic [1:0] BI = 2'(b);
            localparam int unsigned S = c * NUM_BOXES + b;
            logic              hit;
            logic [DATA_W-1:0] set_bits;
            logic [DATA_W-1:0] clr_bits;
            logic [DATA_W-1:0] value;

            assign hit      = wr_hit && sel.core == CI && sel.box == BI;
            assign set_bits = (hit && sel.rgn == RGN_SET) ? req_wdata : '0;
            assign clr_bits = (hit && sel.rgn == RGN_CLR) ? req_wdata : '0;

            mbox_slot #(.DATA_W(DATA_W)) i_slot (
               .clk     (clk),
               .rst_n   (rst_n),
               .set_bits(set_bits),
               .clr_bits(clr_bits),
               .value   (value)
            );

            assign box_flat[S*DATA_W +: DATA_W] = value;
         end

         mbox_irq_merge #(
            .NUM_BOXES(NUM_BOXES),
            .DATA_W   (DATA_W)
         ) i_merge (
            .boxes  (box_flat[c*NUM_BOXES*DATA_W +: NUM_BOXES*DATA_W]),
            .en     (en_q),
            .pending(pend[c])
         );
      end

      if (REG_IRQ) begin : g_irq_reg
         logic [NUM_CORES-1:0] irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= '0;
            else
               irq_q <= pend;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = pend;
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      unique case (sel.rgn)
         RGN_CLR:  rd_word = box_flat[(int'(sel.core) * NUM_BOXES + int'(sel.box)) * DATA_W +: DATA_W];
         RGN_CTRL: rd_word = DATA_W'(en_flat[int'(sel.core) * NUM_BOXES +: NUM_BOXES]);
         default:  rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else
         rdata_q <= rd_hit ? rd_word : '0;
   end

   assign rsp_rdata = rdata_q;

endmodule

// File: rtl/mbox_ipi_ctrl_chk.sv
module mbox_ipi_ctrl_chk
   import mbox_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned NUM_BOXES = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter bit          REG_IRQ   = 1'b0
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  req_vld,
   input logic                                  req_wr,
   input logic [ADDR_W-1:0]                     req_addr,
   input logic [DATA_W-1:0]                     req_wdata,
   input logic [DATA_W-1:0]                     rsp_rdata,
   input logic [NUM_CORES-1:0]                  irq,
   input logic [NUM_CORES*NUM_BOXES*DATA_W-1:0] box_flat,
   input logic [NUM_CORES*NUM_BOXES-1:0]        en_flat
);

   logic any_wr;
   logic any_rd;
   assign any_wr = req_vld &  req_wr;
   assign any_rd = req_vld & ~req_wr;

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
         localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_off(c));

         // R10: enable read returns only the enable bits
         p_ctrl_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (any_rd && req_addr == A_CTRL) |=>
               rsp_rdata == DATA_W'($past(en_flat[c*NUM_BOXES +: NUM_BOXES])));

         if (!REG_IRQ) begin : g_comb
            // R7: without a write nothing can drop a raised line
            p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
               (irq[c] && !any_wr) |=> irq[c]);
            // R6: a raised line needs a non-zero mailbox of this core
            p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
               irq[c] |-> (|box_flat[c*NUM_BOXES*DATA_W +: NUM_BOXES*DATA_W]));
         end

         for (genvar b = 0; b < NUM_BOXES; b++) begin : g_b
            localparam int unsigned S = c * NUM_BOXES + b;
            localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(set_off(c, b));
            localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(clr_off(c, b));

            // R3: set view ORs data in
            p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (any_wr && req_addr == A_SET) |=>
                  box_flat[S*DATA_W +: DATA_W] ==
                  ($past(box_flat[S*DATA_W +: DATA_W]) | $past(req_wdata)));

            // R4: clear view clears written ones
            p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
               (any_wr && req_addr == A_CLR) |=>
                  box_flat[S*DATA_W +: DATA_W] ==
                  ($past(box_flat[S*DATA_W +: DATA_W]) & ~$past(req_wdata)));

            // R12: other accesses leave this mailbox alone
            p_isolate_r12: assert property (@(posedge clk) disable iff (!rst_n)
               !(any_wr && (req_addr == A_SET || req_addr == A_CLR)) |=>
                  $stable(box_flat[S*DATA_W +: DATA_W]));

            // R5: clear view read returns contents one cycle later
            p_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (any_rd && req_addr == A_CLR) |=>
                  rsp_rdata == $past(box_flat[S*DATA_W +: DATA_W]));

            // R9: set view reads as zero
            p_set_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
               (any_rd && req_addr == A_SET) |=> rsp_rdata == '0);
         end
      end
   endgenerate

   // R9: upper unmapped region reads zero
   p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (any_rd && req_addr[7:6] == 2'b11) |=> rsp_rdata == '0);

endmodule

bind mbox_ipi_ctrl mbox_ipi_ctrl_chk #(
   .NUM_CORES(NUM_CORES),
   .NUM_BOXES(NUM_BOXES),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .REG_IRQ  (REG_IRQ)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vld  (req_vld),
   .req_wr   (req_wr),
   .req_addr (req_addr),
   .req_wdata(req_wdata),
   .rsp_rdata(rsp_rdata),
   .irq      (irq),
   .box_flat (box_flat),
   .en_flat  (en_flat)
);

// File: tb/test_mbox_ipi_ctrl.sv
module test_mbox_ipi_ctrl;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic        req_wr = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic [3:0]  irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbox_ipi_ctrl i_mbox_ipi_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_vld  (req_vld),
      .req_wr   (req_wr),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .rsp_rdata(rsp_rdata),
      .irq      (irq)
   );

   function automatic logic [7:0] a_set(int c, int b);
      return 8'(16*c + 4*b);
   endfunction
   function automatic logic [7:0] a_clr(int c, int b);
      return 8'(64 + 16*c + 4*b);
   endfunction
   function automatic logic [7:0] a_ctl(int c);
      return 8'(128 + 4*c);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
   endtask

   task automatic do_rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
      @(negedge clk);
      d = rsp_rdata;
      req_vld = 1'b0;
   endtask

   task automatic wipe();
      for (int c = 0; c < 4; c++) begin
         do_wr(a_ctl(c), 32'h0);
         for (int b = 0; b < 4; b++) do_wr(a_clr(c, b), 32'hFFFF_FFFF);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 rdata", rsp_rdata, 32'h0);
      for (int c = 0; c < 4; c++) begin
         do_rd(a_ctl(c), d);
         chk("R1 enable", d, 32'h0);
         for (int b = 0; b < 4; b++) begin
            do_rd(a_clr(c, b), d);
            chk("R1 mailbox", d, 32'h0);
         end
      end
   endtask

   task automatic t_set_clear();
      logic [31:0] d;
      wipe();
      do_wr(a_set(1, 2), 32'h0000_00F0);
      do_wr(a_set(1, 2), 32'h0000_000F);
      do_rd(a_clr(1, 2), d);
      chk("R3 OR set", d, 32'h0000_00FF);
      do_wr(a_set(1, 2), 32'h0);
      do_rd(a_clr(1, 2), d);
      chk("R11 zero set", d, 32'h0000_00FF);
      do_wr(a_clr(1, 2), 32'h0000_000F);
      do_rd(a_clr(1, 2), d);
      chk("R4 partial clear", d, 32'h0000_00F0);
      do_rd(a_clr(1, 2), d);
      chk("R5 read no side effect", d, 32'h0000_00F0);
      do_rd(a_set(1, 2), d);
      chk("R9 set view reads zero", d, 32'h0);
   endtask

   task automatic t_irq_level();
      logic [31:0] d;
      wipe();
      do_wr(a_set(1, 2), 32'h0000_00F0);
      chk("R8 masked no irq", 32'(irq), 32'h0);
      do_wr(a_ctl(1), 32'h4);
      chk("R6 irq on enable", 32'(irq), 32'h2);
      do_rd(a_ctl(1), d);
      chk("R10 enable read", d, 32'h4);
      do_wr(a_ctl(1), 32'hFFFF_FFFF);
      do_rd(a_ctl(1), d);
      chk("R10 upper bits zero", d, 32'h0000_000F);
      do_wr(a_ctl(1), 32'h4);
      do_wr(a_clr(1, 2), 32'h0000_0030);
      chk("R7 irq held after partial clear", 32'(irq), 32'h2);
      do_wr(a_clr(1, 2), 32'h0000_00C0);
      chk("R7 irq drops at zero", 32'(irq), 32'h0);
   endtask

   task automatic t_doorbell();
      wipe();
      do_wr(a_ctl(2), 32'h1);
      chk("R6 enabled empty no irq", 32'(irq), 32'h0);
      do_wr(a_set(2, 0), 32'h1);
      chk("R6 doorbell raises irq", 32'(irq), 32'h4);
      do_wr(a_set(2, 1), 32'h5);
      chk("R8 masked box no extra effect", 32'(irq), 32'h4);
      do_wr(a_clr(2, 0), 32'h1);
      chk("R8 masked box keeps irq low", 32'(irq), 32'h0);
   endtask

   task automatic t_boot_word();
      logic [31:0] d;
      wipe();
      do_wr(a_set(3, 3), 32'h8000_1000);
      do_rd(a_clr(3, 3), d);
      chk("R2 boot word at core3 box3", d, 32'h8000_1000);
      do_rd(a_clr(2, 3), d);
      chk("R12 other core untouched", d, 32'h0);
      do_rd(a_clr(3, 2), d);
      chk("R12 other box untouched", d, 32'h0);
      chk("R12 no irq without enable", 32'(irq), 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wipe();
      do_wr(a_set(0, 1), 32'h0000_0011);
      do_wr(8'h90, 32'hFFFF_FFFF);
      do_wr(8'hC4, 32'hFFFF_FFFF);
      do_wr(8'h81, 32'hFFFF_FFFF);
      do_wr(8'h45, 32'hFFFF_FFFF);
      do_rd(8'h90, d);
      chk("R9 unmapped read", d, 32'h0);
      do_rd(8'hC4, d);
      chk("R9 upper region read", d, 32'h0);
      do_rd(a_ctl(0), d);
      chk("R9 misaligned write ignored", d, 32'h0);
      do_rd(a_clr(0, 1), d);
      chk("R9 misaligned clear ignored", d, 32'h0000_0011);
      chk("R9 irq unchanged", 32'(irq), 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear();
      t_irq_level();
      t_doorbell();
      t_boot_word();
      t_unmapped();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule